// File: doc/BRIEF.md
# Configurable Matrix Multiply and Filter Engine

This block is a clocked multiply-accumulate core. It takes three 12-bit signed data words per clock and holds a bank of nine 10-bit signed weights, organised as three sets of three. A 2-bit function select chooses how the nine products are formed and summed. The first function is a 3x3 matrix times a 3-vector, giving three 12-bit results per clock. The second is a 9-tap FIR on one stream. The third is a 3x3 window convolver over three image rows. The fourth is a 4x2 window convolver over two rows. One array of nine multipliers serves every function. Only the routing of data samples to the multipliers changes.

In the three filter functions the result lines change role. A 16-bit cascade input is added to the weighted sum. The 16-bit saturated total then leaves on the Z lines together with the low four Y lines. This lets several engines be chained to build longer filters or larger windows. Weights are loaded three at a time: a 2-bit write code selects the set that captures the three weight inputs on the next clock edge.

Top module: `mmf_engine`

## Requirements
- R1: A write code on `coef_we` stores `coef_a`, `coef_b` and `coef_c` into weight set 1, 2 or 3 for codes 01, 10 and 11 respectively, on the next rising edge. Code 00 leaves all nine weights unchanged. Weight order k=0..8 is set1(a,b,c), set2(a,b,c), set3(a,b,c).
- R2: With `mode`=00, X = round(w_set1·(A,B,C)), Y uses set 2 and Z uses set 3. The rounding computes floor((sum + 2^(FRAC-1)) / 2^FRAC), with FRAC=8 by default, so that a weight of 256 means 1.0.
- R3: In `mode`=00, each rounded result is clamped to the range -2048..2047.
- R4: Data and cascade inputs sampled at a rising edge reach the outputs on the following rising edge: two edges from presentation, in every mode.
- R5: In modes 01, 10 and 11, the cascade result is `{res_z, res_y[3:0]}` (res_z is the high 12 bits). `res_x` and `res_y[11:4]` are zero.
- R6: With `mode`=01, A feeds a 9-deep delay line. The sample delayed by k clocks is weighted by weight k.
- R7: In the filter modes, `casc_in` is added to the weighted sum, and the total is clamped to -32768..32767.
- R8: With `mode`=10, A, B and C are rows, each with a 3-deep line. Set n weights the sample delayed n-1 clocks, with lane a/b/c for rows A/B/C.
- R9: With `mode`=11, row A uses weights 0..3 and row B uses weights 4..7, over 4-deep lines. `din_c` has no effect.
- R10: A synchronous active-high `rst` clears the delay lines, the weights and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Function select: 00 matrix, 01 FIR, 10 3x3 window, 11 4x2 window |
| coef_we | input | 2 | Weight set write code |
| coef_a | input | 10 | Weight for lane A of the selected set |
| coef_b | input | 10 | Weight for lane B of the selected set |
| coef_c | input | 10 | Weight for lane C of the selected set |
| din_a | input | 12 | Data A (vector element / stream / row) |
| din_b | input | 12 | Data B |
| din_c | input | 12 | Data C |
| casc_in | input | 16 | Cascade input added in filter modes |
| res_x | output | 12 | Matrix result X; zero in filter modes |
| res_y | output | 12 | Matrix result Y; low 4 bits of cascade result in filter modes |
| res_z | output | 12 | Matrix result Z; high 12 bits of cascade result in filter modes |

## Verification
On every cycle, the assertions check several properties. Weights hold under code 00, and set 1 captures the weight inputs. The output format in the filter modes is correct. A zero vector gives zero matrix results. With all weights zero, the cascade input passes straight through, and reset clears the outputs. The bench scenarios are the only place to see the arithmetic itself. This covers rounding, clamping in both directions, and the two-edge latency. It also covers the tap ordering through impulse responses in each filter mode, and the fact that row C is ignored in the 4x2 mode.

// File: rtl/mmf_pkg.sv
package mmf_pkg;
    localparam int NSETS = 3;
    localparam int NLANE = 3;
    localparam int NCOEF = NSETS * NLANE;
    localparam int WIN42 = 4;

    typedef enum logic [1:0] {
        MODE_MAT    = 2'b00,
        MODE_FIR    = 2'b01,
        MODE_WIN33  = 2'b10,
        MODE_WIN42  = 2'b11
    } mode_e;
endpackage

// File: rtl/mmf_coef_bank.sv
module mmf_coef_bank
    import mmf_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  we,
    input  logic [CW-1:0]               ka,
    input  logic [CW-1:0]               kb,
    input  logic [CW-1:0]               kc,
    output logic [NCOEF-1:0][CW-1:0]    coef_o
);
    for (genvar s = 0; s < NSETS; s++) begin : g_set
        logic [NLANE-1:0][CW-1:0] set_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                set_q <= '0;
            end else if (we == 2'(s + 1)) begin
                set_q <= {kc, kb, ka};
            end
        end
        assign coef_o[s*NLANE +: NLANE] = set_q;
    end
endmodule

// File: rtl/mmf_delay_line.sv
module mmf_delay_line #(
    parameter int W     = 12,
    parameter int DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [W-1:0]                din,
    output logic [DEPTH-1:0][W-1:0]     taps
);
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else begin
            taps[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end
endmodule

// File: rtl/mmf_mac.sv
module mmf_mac
    import mmf_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CW   = 10,
    parameter int CASW = 16,
    parameter int ACCW = 27
) (
    input  logic [1:0]                  mode,
    input  logic [NCOEF-1:0][DW-1:0]    ta,
    input  logic [WIN42-1:0][DW-1:0]    tb,
    input  logic [NSETS-1:0][DW-1:0]    tc,
    input  logic [NCOEF-1:0][CW-1:0]    coef,
    input  logic signed [CASW-1:0]      cin,
    output logic signed [ACCW-1:0]      acc0,
    output logic signed [ACCW-1:0]      acc1,
    output logic signed [ACCW-1:0]      acc2
);
    function automatic logic signed [ACCW-1:0] mul(
        input logic signed [DW-1:0] d,
        input logic signed [CW-1:0] k
    );
        logic signed [ACCW-1:0] de;
        logic signed [ACCW-1:0] ke;
        de = ACCW'(d);
        ke = ACCW'(k);
        return de * ke;
    endfunction

    always_comb begin
        acc0 = '0;
        acc1 = '0;
        acc2 = '0;
        unique case (mode_e'(mode))
            MODE_MAT: begin
                acc0 = mul(ta[0], coef[0]) + mul(tb[0], coef[1]) + mul(tc[0], coef[2]);
                acc1 = mul(ta[0], coef[3]) + mul(tb[0], coef[4]) + mul(tc[0], coef[5]);
                acc2 = mul(ta[0], coef[6]) + mul(tb[0], coef[7]) + mul(tc[0], coef[8]);
            end
            MODE_FIR: begin
                acc0 = ACCW'(cin);
                for (int k = 0; k < NCOEF; k++) begin
                    acc0 = acc0 + mul(ta[k], coef[k]);
                end
            end
            MODE_WIN33: begin
                acc0 = ACCW'(cin);
                for (int n = 0; n < NSETS; n++) begin
                    acc0 = acc0 + mul(ta[n], coef[n*NLANE])
                                + mul(tb[n], coef[n*NLANE+1])
                                + mul(tc[n], coef[n*NLANE+2]);
                end
            end
            MODE_WIN42: begin
                acc0 = ACCW'(cin);
                for (int j = 0; j < WIN42; j++) begin
                    acc0 = acc0 + mul(ta[j], coef[j]) + mul(tb[j], coef[WIN42+j]);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mmf_engine.sv
module mmf_engine
    import mmf_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CW   = 10,
    parameter int CASW = 16,
    parameter int FRAC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic [1:0]      coef_we,
    input  logic [CW-1:0]   coef_a,
    input  logic [CW-1:0]   coef_b,
    input  logic [CW-1:0]   coef_c,
    input  logic [DW-1:0]   din_a,
    input  logic [DW-1:0]   din_b,
    input  logic [DW-1:0]   din_c,
    input  logic [CASW-1:0] casc_in,
    output logic [DW-1:0]   res_x,
    output logic [DW-1:0]   res_y,
    output logic [DW-1:0]   res_z
);
    localparam int ACCW = DW + CW + $clog2(NCOEF) + 1;
    localparam int YLOW = CASW - DW;
    localparam logic signed [ACCW-1:0] HALF = ACCW'(2 ** (FRAC - 1));
    localparam logic signed [ACCW-1:0] OMAX = ACCW'(2 ** (DW - 1) - 1);
    localparam logic signed [ACCW-1:0] OMIN = ACCW'(-(2 ** (DW - 1)));
    localparam logic signed [ACCW-1:0] CMAX = ACCW'(2 ** (CASW - 1) - 1);
    localparam logic signed [ACCW-1:0] CMIN = ACCW'(-(2 ** (CASW - 1)));

    typedef struct packed {
        logic [CASW-1:0] cin;
        logic [DW-1:0]   x;
        logic [DW-1:0]   y;
        logic [DW-1:0]   z;
    } st_t;

    st_t st_d, st_q;

    logic [NCOEF-1:0][CW-1:0] coef_vec;
    logic [NCOEF-1:0][DW-1:0] taps_a;
    logic [WIN42-1:0][DW-1:0] taps_b;
    logic [NSETS-1:0][DW-1:0] taps_c;
    logic signed [ACCW-1:0]   acc0, acc1, acc2;

    mmf_coef_bank #(.CW(CW)) u_bank (
        .clk(clk), .rst(rst), .we(coef_we),
        .ka(coef_a), .kb(coef_b), .kc(coef_c), .coef_o(coef_vec)
    );

    mmf_delay_line #(.W(DW), .DEPTH(NCOEF)) u_line_a (
        .clk(clk), .rst(rst), .din(din_a), .taps(taps_a)
    );
    mmf_delay_line #(.W(DW), .DEPTH(WIN42)) u_line_b (
        .clk(clk), .rst(rst), .din(din_b), .taps(taps_b)
    );
    mmf_delay_line #(.W(DW), .DEPTH(NSETS)) u_line_c (
        .clk(clk), .rst(rst), .din(din_c), .taps(taps_c)
    );

    mmf_mac #(.DW(DW), .CW(CW), .CASW(CASW), .ACCW(ACCW)) u_mac (
        .mode(mode), .ta(taps_a), .tb(taps_b), .tc(taps_c),
        .coef(coef_vec), .cin($signed(st_q.cin)),
        .acc0(acc0), .acc1(acc1), .acc2(acc2)
    );

    function automatic logic [DW-1:0] round_clamp(input logic signed [ACCW-1:0] s);
        logic signed [ACCW-1:0] t;
        t = (s + HALF) >>> FRAC;
        if (t > OMAX)      return OMAX[DW-1:0];
        else if (t < OMIN) return OMIN[DW-1:0];
        else               return t[DW-1:0];
    endfunction

    function automatic logic [CASW-1:0] casc_clamp(input logic signed [ACCW-1:0] s);
        if (s > CMAX)      return CMAX[CASW-1:0];
        else if (s < CMIN) return CMIN[CASW-1:0];
        else               return s[CASW-1:0];
    endfunction

    always_comb begin
        logic [CASW-1:0] f;
        st_d     = st_q;
        st_d.cin = casc_in;
        f        = casc_clamp(acc0);
        if (mode_e'(mode) == MODE_MAT) begin
            st_d.x = round_clamp(acc0);
            st_d.y = round_clamp(acc1);
            st_d.z = round_clamp(acc2);
        end else begin
            st_d.x = '0;
            st_d.y = {{(DW-YLOW){1'b0}}, f[YLOW-1:0]};
            st_d.z = f[CASW-1:YLOW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_x = st_q.x;
    assign res_y = st_q.y;
    assign res_z = st_q.z;
endmodule

// File: rtl/mmf_engine_chk.sv
module mmf_engine_chk
    import mmf_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CW   = 10,
    parameter int CASW = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [1:0]               mode,
    input logic [1:0]               coef_we,
    input logic [CW-1:0]            coef_a,
    input logic [CW-1:0]            coef_b,
    input logic [CW-1:0]            coef_c,
    input logic [NCOEF-1:0][CW-1:0] coef_vec,
    input logic [DW-1:0]            tap_a0,
    input logic [DW-1:0]            tap_b0,
    input logic [DW-1:0]            tap_c0,
    input logic [CASW-1:0]          cin_q,
    input logic [DW-1:0]            res_x,
    input logic [DW-1:0]            res_y,
    input logic [DW-1:0]            res_z
);
    localparam int YLOW = CASW - DW;

    AST_HOLD_SETS: assert property (@(posedge clk) disable iff (rst)
        coef_we == 2'b00 |=> $stable(coef_vec)); // R1

    AST_LOAD_SET1: assert property (@(posedge clk) disable iff (rst)
        coef_we == 2'b01 |=> coef_vec[NLANE-1:0] == $past({coef_c, coef_b, coef_a})); // R1

    AST_MAT_ZERO_VEC: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 2'b00 && $past(tap_a0) == '0 && $past(tap_b0) == '0 && $past(tap_c0) == '0)
        |-> (res_x == '0 && res_y == '0 && res_z == '0)); // R2

    AST_FILT_FORMAT: assert property (@(posedge clk) disable iff (rst)
        $past(mode) != 2'b00 |-> (res_x == '0 && res_y[DW-1:YLOW] == '0)); // R5

    AST_CASC_PASS: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) != 2'b00 && $past(coef_vec) == '0)
        |-> {res_z, res_y[YLOW-1:0]} == $past(cin_q)); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) === 1'b1 |-> (res_x == '0 && res_y == '0 && res_z == '0)); // R10
endmodule

bind mmf_engine mmf_engine_chk #(.DW(DW), .CW(CW), .CASW(CASW)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .coef_we(coef_we),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c), .coef_vec(coef_vec),
    .tap_a0(taps_a[0]), .tap_b0(taps_b[0]), .tap_c0(taps_c[0]),
    .cin_q(st_q.cin), .res_x(res_x), .res_y(res_y), .res_z(res_z)
);

// File: tb/sim_mmf_engine.sv
module sim_mmf_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = '0, coef_we = '0;
    logic [9:0]  coef_a = '0, coef_b = '0, coef_c = '0;
    logic [11:0] din_a = '0, din_b = '0, din_c = '0;
    logic [15:0] casc_in = '0;
    logic [11:0] res_x, res_y, res_z;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    mmf_engine u0 (
        .clk(clk), .rst(rst), .mode(mode), .coef_we(coef_we),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .din_a(din_a), .din_b(din_b), .din_c(din_c), .casc_in(casc_in),
        .res_x(res_x), .res_y(res_y), .res_z(res_z)
    );

    // A, B, C -> X, Y, Z with set1=(256,0,0), set2=(128,128,0), set3=(0,0,-256)
    localparam int NV = 5;
    localparam int VEC [NV][6] = '{
        '{100, 50, 7, 100, 75, -7},
        '{-3, 0, -2048, -3, -1, 2047},
        '{2047, 2047, 2047, 2047, 2047, -2047},
        '{-2048, -2048, 0, -2048, -2048, 0},
        '{1, 0, 5, 1, 1, -5}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] s, input int a, input int b, input int c);
        coef_we = s; coef_a = 10'(a); coef_b = 10'(b); coef_c = 10'(c);
        cyc(1);
        coef_we = 2'b00;
    endtask

    task automatic drive(input int a, input int b, input int c);
        din_a = 12'(a); din_b = 12'(b); din_c = 12'(c);
    endtask

    function automatic int casc();
        return int'($signed({res_z, res_y[3:0]}));
    endfunction

    task automatic check_mat(input string tag, input int x, input int y, input int z);
        check({tag, " X"}, int'($signed(res_x)), x);
        check({tag, " Y"}, int'($signed(res_y)), y);
        check({tag, " Z"}, int'($signed(res_z)), z);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        check_mat("R10 reset outputs", 0, 0, 0);
        drive(100, 100, 100);
        cyc(2);
        check_mat("R10 weights cleared", 0, 0, 0);

        load(2'b01, 256, 0, 0);
        load(2'b10, 128, 128, 0);
        load(2'b11, 0, 0, -256);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][0], VEC[i][1], VEC[i][2]);
            cyc(2);
            check_mat($sformatf("R2 R3 vector %0d", i), VEC[i][3], VEC[i][4], VEC[i][5]);
        end

        // R1: code 00 ignores the weight inputs
        coef_we = 2'b00; coef_a = 10'd77; coef_b = 10'd77; coef_c = 10'd77;
        drive(100, 50, 7);
        cyc(2);
        check_mat("R1 hold code 00", 100, 75, -7);

        // R4: latency of two edges in matrix mode
        drive(1, 0, 5);
        cyc(1);
        check("R4 mat after one edge", int'($signed(res_x)), 100);
        cyc(1);
        check("R4 mat after two edges", int'($signed(res_x)), 1);

        // R3: clamp both ways
        load(2'b01, 511, 511, 0);
        drive(-2048, -2048, 0);
        cyc(2);
        check("R3 negative clamp", int'($signed(res_x)), -2048);
        drive(2047, 2047, 0);
        cyc(2);
        check("R3 positive clamp", int'($signed(res_x)), 2047);

        // FIR weights 1..9
        load(2'b01, 1, 2, 3);
        load(2'b10, 4, 5, 6);
        load(2'b11, 7, 8, 9);
        mode = 2'b01; casc_in = '0; drive(0, 0, 0);
        cyc(10);
        check("R5 X zero in filter mode", int'(res_x), 0);
        check("R5 Y high zero", int'(res_y[11:4]), 0);
        drive(1, 0, 0);
        cyc(1);
        drive(0, 0, 0);
        check("R4 fir after one edge", casc(), 0);
        for (int k = 0; k < 10; k++) begin
            cyc(1);
            check($sformatf("R6 fir tap %0d", k), casc(), (k < 9) ? k + 1 : 0);
        end
        casc_in = 16'd1000;
        cyc(2);
        check("R7 cascade added", casc(), 1000);
        drive(1000, 0, 0);
        cyc(10);
        check("R7 positive clamp", casc(), 32767);
        drive(-1000, 0, 0); casc_in = 16'($signed(-1000));
        cyc(10);
        check("R7 negative clamp", casc(), -32768);

        // 3x3 window
        mode = 2'b10; casc_in = 16'd5; drive(1, 10, 100);
        cyc(4);
        check("R8 window33 steady", casc(), 1967);
        casc_in = '0; drive(0, 0, 0);
        cyc(4);
        drive(0, 1, 0);
        cyc(1);
        drive(0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            cyc(1);
            check($sformatf("R8 column order %0d", k), casc(), (k == 0) ? 2 : (k == 1) ? 5 : (k == 2) ? 8 : 0);
        end

        // 4x2 window
        mode = 2'b11; drive(1, 10, 1000);
        cyc(5);
        check("R9 window42 with C", casc(), 270);
        drive(1, 10, 0);
        cyc(2);
        check("R9 C ignored", casc(), 270);
        drive(0, 0, 0);
        cyc(5);
        drive(1, 0, 0);
        cyc(1);
        drive(0, 0, 0);
        for (int k = 0; k < 5; k++) begin
            cyc(1);
            check($sformatf("R9 row A tap %0d", k), casc(), (k < 4) ? k + 1 : 0);
        end

        // R10: mid-run reset clears outputs and weights
        drive(5, 5, 5); casc_in = '0;
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        check_mat("R10 reset mid run", 0, 0, 0);
        mode = 2'b00;
        cyc(2);
        check_mat("R10 weights after reset", 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule